// File: doc/BRIEF.md
# SMBus Register Slave with Bus Timeout and Alert

This block attaches a small bank of byte registers to a two-wire SMBus segment. It only ever pulls SDA low and never drives SCL, so the bus may be stretched by other agents. Both line inputs pass through synchronizers. START and STOP are recognised as SDA edges while SCL is high. The block answers its own 7-bit address for byte writes and byte reads. In a write, the first data byte loads an internal register pointer and the second byte is stored at that pointer. A read returns the byte at the pointer, normally after a repeated START that follows a pointer-only write.

A set of event inputs feeds sticky status bits. Each status bit has a mask bit, and a global interrupt-enable bit sits in a control register. Together these drive an active-low alert line. While the alert is active, the block also responds to the Alert Response Address by returning its own address. It then drops the alert until a further enabled event arrives.

A transfer is abandoned if SCL stays low for longer than a configurable number of system clocks. The default is 30 ms at 100 MHz. A START followed at once by a STOP returns the interface to idle. A system-side port reads and writes the same register map.

Top module: `smb_reg_slave`

## Requirements
- R1: A write transfer to the own address (default 0x2E) is acknowledged. Its first data byte sets the pointer, and its second data byte is stored at the pointer. Register map: scratch bytes at 0x00..0x07, status at 0x41, mask at 0x42, control at 0x7C.
- R2: After a pointer write, a repeated START and a read of the own address return the byte held at the pointer, MSB first.
- R3: A read from any address outside the register map returns 0x00.
- R4: A write to an address outside the register map is acknowledged and changes no register.
- R5: The general call address (0x00) and any foreign address are not acknowledged, and SDA stays released.
- R6: If SCL stays low for TIMEOUT_CYCLES clocks during a transfer, SDA is released and the interface goes idle. A later START is then accepted.
- R7: A START followed directly by a STOP leaves the interface idle with SDA released. Bytes clocked afterwards without a new START get no acknowledge.
- R8: Status bit i is set by a pulse on event input i and stays set. Writing 1 to a status bit over the bus clears it. alert_n_o is low only when control bit 2 is 1 and some status bit has its mask bit at 1.
- R9: The read address 0001100 is acknowledged only while alert_n_o is low. The byte returned is the own address shifted left with LSB 0 (0x5C by default). After that byte, alert_n_o goes high until a new enabled event bit is set.
- R10: SDA pull-down only begins while the synchronized SCL is low. The block has no SCL output.
- R11: The system-side port writes the scratch, mask and control registers and reads the whole map combinationally. The status register is read-only from that side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| sys_we_i | input | 1 | System-side write strobe |
| sys_addr_i | input | 8 | System-side register address |
| sys_wdata_i | input | 8 | System-side write data |
| sys_rdata_o | output | 8 | System-side read data |
| evt_i | input | NUM_EVENTS | Event pulses into the status bits |
| alert_n_o | output | 1 | Active-low alert |

## Verification
The assertions assume that SCL stays high or low for several system clocks. They also assume that SDA changes only while SCL is low, except when a START or STOP is being formed. Under these conditions a fall of SCL is seen before the slave drives its next bit. The bench's master holds each SCL phase for twelve clocks. It waits four clocks after each SCL fall before changing SDA, so the slave's three-cycle response always lands inside the low phase. Event pulses are one clock wide and never coincide with the end of an alert-response byte.

// File: rtl/smb_pkg.sv
// Shared types and register map constants for the SMBus register slave.
// Assumes 8-bit register addressing.
package smb_pkg;

    typedef enum logic [3:0] {
        L_IDLE,
        L_ADDR,
        L_AACK,
        L_WDATA,
        L_WACK,
        L_RDATA,
        L_MACK,
        L_RLOAD,
        L_SKIP
    } link_st_e;

    localparam logic [7:0] REG_STATUS  = 8'h41;
    localparam logic [7:0] REG_MASK    = 8'h42;
    localparam logic [7:0] REG_CTRL    = 8'h7C;
    localparam int         CTRL_IE_BIT = 2;
    localparam logic [6:0] ARA_ADDR    = 7'b0001100;

endpackage

// File: rtl/smb_line_sync.sv
// Synchronizes SCL and SDA into the system clock domain and derives
// SCL edges plus START/STOP conditions. Assumes STAGES >= 2 and that
// each line level lasts several clocks.
module smb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s_o,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    // Shift both lines through their synchronizer chains, idle high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    // Edge and bus-condition decode from current and previous samples.
    always_comb begin
        scl_s_o    = scl_q[STAGES-1];
        sda_s_o    = sda_q[STAGES-1];
        scl_rise_o = scl_s_o & ~scl_d;
        scl_fall_o = ~scl_s_o & scl_d;
        start_o    = scl_s_o & scl_d & sda_d & ~sda_s_o;
        stop_o     = scl_s_o & scl_d & ~sda_d & sda_s_o;
    end

endmodule

// File: rtl/smb_timeout.sv
// Counts system clocks while a transfer is open and SCL is low; flags
// expiry after LIMIT such clocks. Assumes LIMIT >= 2.
module smb_timeout #(
    parameter int LIMIT = 3_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic scl_s_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    logic          active;

    // Low-time measurement is live only inside a transfer.
    always_comb begin
        active   = busy_i & ~scl_s_i;
        expire_o = active && (cnt == CW'(LIMIT - 1));
    end

    // Advance while SCL is held low, restart otherwise or on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || expire_o) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/smb_regfile.sv
// Register bank with scratch bytes, sticky event status, mask and control.
// Produces the active-low alert and the alert-response permission.
// Assumes NUM_EVENTS <= 8 and NSCR <= 0x41.
module smb_regfile
    import smb_pkg::*;
#(
    parameter int NSCR       = 8,
    parameter int NUM_EVENTS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we_i,
    input  logic [7:0]            bus_waddr_i,
    input  logic [7:0]            bus_wdata_i,
    input  logic [7:0]            bus_raddr_i,
    output logic [7:0]            bus_rdata_o,
    input  logic                  sys_we_i,
    input  logic [7:0]            sys_addr_i,
    input  logic [7:0]            sys_wdata_i,
    output logic [7:0]            sys_rdata_o,
    input  logic [NUM_EVENTS-1:0] evt_i,
    input  logic                  ara_done_i,
    output logic                  alert_n_o
);
    localparam int IW = (NSCR > 1) ? $clog2(NSCR) : 1;

    logic [NSCR-1:0][7:0] scr;
    logic [7:0]           status_q;
    logic [7:0]           mask_q;
    logic [7:0]           ctl_q;
    logic                 quiet_q;
    logic [7:0]           evt_w;
    logic [7:0]           w1c;
    logic                 pending;
    logic                 new_evt;
    logic [7:0]           rp_a [2];

    // Tells whether an address belongs to the register map.
    function automatic logic is_defined(input logic [7:0] a);
        return (a < 8'(NSCR)) || (a == REG_STATUS) || (a == REG_MASK) || (a == REG_CTRL);
    endfunction

    // Event widening, clear mask from bus writes, and alert decision.
    always_comb begin
        evt_w     = 8'(evt_i);
        w1c       = (bus_we_i && bus_waddr_i == REG_STATUS) ? bus_wdata_i : 8'h00;
        pending   = ctl_q[CTRL_IE_BIT] && |(status_q & mask_q);
        new_evt   = |(evt_w & ~status_q & mask_q);
        alert_n_o = ~(pending && !quiet_q);
        rp_a[0]   = bus_raddr_i;
        rp_a[1]   = sys_addr_i;
    end

    // Two identical read decoders: one for the bus, one for the system port.
    for (genvar p = 0; p < 2; p++) begin : g_rd
        logic [7:0] d;
        // Map lookup with 00h for undefined addresses.
        always_comb begin
            d = 8'h00;
            if (rp_a[p] < 8'(NSCR)) begin
                d = scr[rp_a[p][IW-1:0]];
            end else begin
                case (rp_a[p])
                    REG_STATUS: d = status_q;
                    REG_MASK:   d = mask_q;
                    REG_CTRL:   d = ctl_q;
                    default:    d = 8'h00;
                endcase
            end
        end
    end

    assign bus_rdata_o = g_rd[0].d;
    assign sys_rdata_o = g_rd[1].d;

    // Writable registers; the system port takes precedence on a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scr    <= '0;
            mask_q <= 8'h00;
            ctl_q  <= 8'h00;
        end else begin
            for (int i = 0; i < NSCR; i++) begin
                if (bus_we_i && bus_waddr_i == 8'(i)) scr[i] <= bus_wdata_i;
                if (sys_we_i && sys_addr_i == 8'(i))  scr[i] <= sys_wdata_i;
            end
            if (bus_we_i && bus_waddr_i == REG_MASK) mask_q <= bus_wdata_i;
            if (sys_we_i && sys_addr_i == REG_MASK)  mask_q <= sys_wdata_i;
            if (bus_we_i && bus_waddr_i == REG_CTRL) ctl_q  <= bus_wdata_i;
            if (sys_we_i && sys_addr_i == REG_CTRL)  ctl_q  <= sys_wdata_i;
        end
    end

    // Sticky status with write-one-to-clear from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= 8'h00;
        else        status_q <= (status_q & ~w1c) | evt_w;
    end

    // Alert hold-off after an alert-response read, rearmed by new events.
    always_ff @(posedge clk) begin
        if (!rst_n)                    quiet_q <= 1'b0;
        else if (ara_done_i)           quiet_q <= 1'b1;
        else if (new_evt || !pending)  quiet_q <= 1'b0;
    end

    // R4
    undef_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && !is_defined(bus_waddr_i) && !sys_we_i)
        |=> ($stable(scr) && $stable(mask_q) && $stable(ctl_q)));

    // R9
    ara_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ara_done_i |=> alert_n_o);

endmodule

// File: rtl/smb_link.sv
// Bit and byte sequencer of the slave: address match, acknowledge,
// pointer load, register write pulse and read shifting. Samples SDA on
// SCL rise, changes its SDA pull on SCL fall. Assumes DEV_ADDR != 0.
module smb_link
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s_i,
    input  logic       sda_s_i,
    input  logic       scl_rise_i,
    input  logic       scl_fall_i,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       tmo_i,
    input  logic       ara_ok_i,
    input  logic [7:0] reg_rdata_i,
    output logic [7:0] reg_raddr_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       ara_done_o,
    output logic       busy_o,
    output logic       sda_pull_o
);
    link_st_e   st;
    logic [3:0] cnt;
    logic [7:0] sh;
    logic [7:0] tx;
    logic [7:0] ptr;
    logic [7:0] tx_byte;
    logic       rw;
    logic       ara_m;
    logic       first;

    // Byte to transmit next: own address for an alert response, else register.
    always_comb begin
        tx_byte     = ara_m ? {DEV_ADDR, 1'b0} : reg_rdata_i;
        reg_raddr_o = ptr;
        wr_addr_o   = ptr;
        wr_data_o   = sh;
        busy_o      = (st != L_IDLE);
    end

    // Transfer sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= L_IDLE;
            cnt        <= 4'd0;
            sh         <= 8'h00;
            tx         <= 8'h00;
            ptr        <= 8'h00;
            rw         <= 1'b0;
            ara_m      <= 1'b0;
            first      <= 1'b1;
            wr_en_o    <= 1'b0;
            ara_done_o <= 1'b0;
            sda_pull_o <= 1'b0;
        end else begin
            wr_en_o    <= 1'b0;
            ara_done_o <= 1'b0;
            if (tmo_i || stop_i) begin
                st         <= L_IDLE;
                sda_pull_o <= 1'b0;
            end else if (start_i) begin
                st         <= L_ADDR;
                cnt        <= 4'd0;
                first      <= 1'b1;
                sda_pull_o <= 1'b0;
            end else begin
                case (st)
                    L_ADDR: begin
                        if (scl_rise_i) begin
                            sh  <= {sh[6:0], sda_s_i};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall_i && cnt == 4'd8) begin
                            rw <= sh[0];
                            if (sh[7:1] == DEV_ADDR) begin
                                ara_m      <= 1'b0;
                                sda_pull_o <= 1'b1;
                                st         <= L_AACK;
                            end else if (sh[7:1] == ARA_ADDR && sh[0] && ara_ok_i) begin
                                ara_m      <= 1'b1;
                                sda_pull_o <= 1'b1;
                                st         <= L_AACK;
                            end else begin
                                st <= L_SKIP;
                            end
                        end
                    end
                    L_AACK, L_RLOAD: begin
                        if (scl_fall_i) begin
                            if (rw) begin
                                sda_pull_o <= ~tx_byte[7];
                                tx         <= {tx_byte[6:0], 1'b0};
                                cnt        <= 4'd1;
                                st         <= L_RDATA;
                            end else begin
                                sda_pull_o <= 1'b0;
                                cnt        <= 4'd0;
                                st         <= L_WDATA;
                            end
                        end
                    end
                    L_WDATA: begin
                        if (scl_rise_i) begin
                            sh  <= {sh[6:0], sda_s_i};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall_i && cnt == 4'd8) begin
                            if (first) begin
                                ptr   <= sh;
                                first <= 1'b0;
                            end else begin
                                wr_en_o <= 1'b1;
                            end
                            sda_pull_o <= 1'b1;
                            st         <= L_WACK;
                        end
                    end
                    L_WACK: begin
                        if (scl_fall_i) begin
                            sda_pull_o <= 1'b0;
                            cnt        <= 4'd0;
                            st         <= L_WDATA;
                        end
                    end
                    L_RDATA: begin
                        if (scl_fall_i) begin
                            if (cnt == 4'd8) begin
                                sda_pull_o <= 1'b0;
                                st         <= L_MACK;
                                if (ara_m) ara_done_o <= 1'b1;
                            end else begin
                                sda_pull_o <= ~tx[7];
                                tx         <= {tx[6:0], 1'b0};
                                cnt        <= cnt + 4'd1;
                            end
                        end
                    end
                    L_MACK: begin
                        if (scl_rise_i) st <= sda_s_i ? L_SKIP : L_RLOAD;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R6
    tmo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_i |=> (st == L_IDLE && !sda_pull_o));

    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (st == L_IDLE && !sda_pull_o));

    // R5
    gencall_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == L_ADDR && scl_fall_i && cnt == 4'd8 && sh[7:1] == 7'd0 && !start_i && !stop_i && !tmo_i)
        |=> (st == L_SKIP && !sda_pull_o));

    // R10
    pull_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s_i);

endmodule

// File: rtl/smb_reg_slave.sv
// Top of the SMBus register slave: line synchronizers, SCL-low timeout,
// transfer sequencer and register bank. Drives only an SDA pull-down.
// Assumes DEV_ADDR is neither 0 nor the alert response address.
module smb_reg_slave #(
    parameter logic [6:0] DEV_ADDR       = 7'h2E,
    parameter int         TIMEOUT_CYCLES = 3_000_000,
    parameter int         NUM_SCRATCH    = 8,
    parameter int         NUM_EVENTS     = 4,
    parameter int         SYNC_STAGES    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_pull_o,
    input  logic                  sys_we_i,
    input  logic [7:0]            sys_addr_i,
    input  logic [7:0]            sys_wdata_i,
    output logic [7:0]            sys_rdata_o,
    input  logic [NUM_EVENTS-1:0] evt_i,
    output logic                  alert_n_o
);
    logic       scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    logic       tmo, busy;
    logic [7:0] raddr, rdata, waddr, wdata;
    logic       wr_en, ara_done;

    smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_s_o    (scl_s),
        .sda_s_o    (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_c),
        .stop_o     (stop_c)
    );

    smb_timeout #(.LIMIT(TIMEOUT_CYCLES)) i_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (busy),
        .scl_s_i  (scl_s),
        .expire_o (tmo)
    );

    smb_link #(.DEV_ADDR(DEV_ADDR)) i_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s_i     (scl_s),
        .sda_s_i     (sda_s),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_c),
        .stop_i      (stop_c),
        .tmo_i       (tmo),
        .ara_ok_i    (~alert_n_o),
        .reg_rdata_i (rdata),
        .reg_raddr_o (raddr),
        .wr_en_o     (wr_en),
        .wr_addr_o   (waddr),
        .wr_data_o   (wdata),
        .ara_done_o  (ara_done),
        .busy_o      (busy),
        .sda_pull_o  (sda_pull_o)
    );

    smb_regfile #(.NSCR(NUM_SCRATCH), .NUM_EVENTS(NUM_EVENTS)) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we_i    (wr_en),
        .bus_waddr_i (waddr),
        .bus_wdata_i (wdata),
        .bus_raddr_i (raddr),
        .bus_rdata_o (rdata),
        .sys_we_i    (sys_we_i),
        .sys_addr_i  (sys_addr_i),
        .sys_wdata_i (sys_wdata_i),
        .sys_rdata_o (sys_rdata_o),
        .evt_i       (evt_i),
        .ara_done_i  (ara_done),
        .alert_n_o   (alert_n_o)
    );

endmodule

// File: tb/test_smb_reg_slave.sv
// Scoreboard bench: the bus master tasks queue expected read bytes, a
// monitor process pops and compares them against bytes actually received.
module test_smb_reg_slave;
    localparam int         H    = 12;
    localparam int         TMO  = 300;
    localparam logic [6:0] DEV  = 7'h2E;
    localparam logic [7:0] AW   = {DEV, 1'b0};
    localparam logic [7:0] AR   = {DEV, 1'b1};
    localparam logic [7:0] ARA_R = 8'h19;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_pull;
    logic       sda_line;
    logic       sys_we = 1'b0;
    logic [7:0] sys_addr = 8'h00;
    logic [7:0] sys_wdata = 8'h00;
    logic [7:0] sys_rdata;
    logic [3:0] evt = 4'h0;
    logic       alert_n;

    always #4 clk = ~clk;
    assign sda_line = m_sda & ~sda_pull;

    smb_reg_slave #(.DEV_ADDR(DEV), .TIMEOUT_CYCLES(TMO)) i_smb_reg_slave (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .sys_we_i    (sys_we),
        .sys_addr_i  (sys_addr),
        .sys_wdata_i (sys_wdata),
        .sys_rdata_o (sys_rdata),
        .evt_i       (evt),
        .alert_n_o   (alert_n)
    );

    int n_run = 0;
    int n_fail = 0;
    int r10_viol = 0;
    logic prev_pull = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] act_q[$];

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // Scoreboard monitor: compares each received byte with its queued expectation.
    always @(negedge clk) begin
        if (act_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, 32'(a), 32'(e));
        end
    end

    // R10 observer: a new SDA pull must not start while SCL is high.
    always @(negedge clk) begin
        if (rst_n && sda_pull && !prev_pull && m_scl) r10_viol++;
        prev_pull <= sda_pull;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic b_start();
        m_sda = 1'b1; m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic b_rstart();
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic b_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic wbit(input logic b);
        m_sda = b; tick(H);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic rbit(output logic b);
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H / 2);
        b = sda_line; tick(H / 2);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic wbyte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(d[i]);
        rbit(b);
        acked = ~b;
    endtask

    task automatic rbyte(output logic [7:0] d, input logic last);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            d[i] = b;
        end
        wbit(last);
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d, input string r);
        logic ack;
        b_start();
        wbyte(AW, ack); chk({r, " addr ack"}, 32'(ack), 1);
        wbyte(a, ack);  chk({r, " ptr ack"}, 32'(ack), 1);
        wbyte(d, ack);  chk({r, " data ack"}, 32'(ack), 1);
        b_stop();
    endtask

    task automatic reg_read(input logic [7:0] a, input logic [7:0] e, input string r);
        logic ack;
        logic [7:0] d;
        b_start();
        wbyte(AW, ack); chk({r, " addr ack"}, 32'(ack), 1);
        wbyte(a, ack);  chk({r, " ptr ack"}, 32'(ack), 1);
        b_rstart();
        wbyte(AR, ack); chk({r, " read ack"}, 32'(ack), 1);
        exp_q.push_back(e);
        tag_q.push_back({r, " read data"});
        rbyte(d, 1'b1);
        act_q.push_back(d);
        b_stop();
    endtask

    task automatic ara_read(input logic exp_ack, input string r);
        logic ack;
        logic [7:0] d;
        b_start();
        wbyte(ARA_R, ack);
        chk({r, " ara ack"}, 32'(ack), 32'(exp_ack));
        if (ack) begin
            exp_q.push_back(AW);
            tag_q.push_back({r, " ara byte"});
            rbyte(d, 1'b1);
            act_q.push_back(d);
        end
        b_stop();
    endtask

    task automatic pulse_evt(input int k);
        evt[k] = 1'b1; tick(1);
        evt = 4'h0; tick(2);
    endtask

    logic [7:0] snap [256];
    bit done = 1'b0;

    // Watchdog: a hung run becomes a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        tick(6);
        // Reset state
        chk("R10 reset sda release", 32'(sda_pull), 0);
        chk("R8 reset alert", 32'(alert_n), 1);
        sys_addr = 8'h7C; #1;
        chk("R11 reset ctrl", 32'(sys_rdata), 0);
        rst_n = 1'b1;
        tick(4);

        // R1 byte write, seen on the system side
        reg_write(8'h03, 8'hA5, "R1");
        sys_addr = 8'h03; #1;
        chk("R1 stored value", 32'(sys_rdata), 32'hA5);

        // R2 byte reads
        reg_read(8'h03, 8'hA5, "R2");
        reg_write(8'h00, 8'h5A, "R1");
        reg_read(8'h00, 8'h5A, "R2");

        // R11 system write seen over the bus; status not writable from system side
        @(negedge clk);
        sys_addr = 8'h05; sys_wdata = 8'h3C; sys_we = 1'b1;
        @(negedge clk);
        sys_addr = 8'h41; sys_wdata = 8'hFF;
        @(negedge clk);
        sys_we = 1'b0;
        reg_read(8'h05, 8'h3C, "R11");
        sys_addr = 8'h41; #1;
        chk("R11 status read-only", 32'(sys_rdata), 0);

        // R3 undefined reads
        reg_read(8'h20, 8'h00, "R3");
        reg_read(8'h7D, 8'h00, "R3");

        // R4 undefined write: acknowledged, map unchanged
        for (int a = 0; a < 256; a++) begin
            sys_addr = 8'(a); #1;
            snap[a] = sys_rdata;
        end
        reg_write(8'h20, 8'hFF, "R4");
        begin
            int diffs;
            diffs = 0;
            for (int a = 0; a < 256; a++) begin
                sys_addr = 8'(a); #1;
                if (sys_rdata !== snap[a]) diffs++;
            end
            chk("R4 register map unchanged", 32'(diffs), 0);
        end
        tick(1);

        // R5 general call and foreign address
        b_start();
        wbyte(8'h00, ack);
        chk("R5 general call nack", 32'(ack), 0);
        b_stop();
        b_start();
        wbyte({7'h33, 1'b0}, ack);
        chk("R5 foreign address nack", 32'(ack), 0);
        b_stop();
        chk("R5 sda released", 32'(sda_pull), 0);

        // R6 SCL held low during the address acknowledge
        b_start();
        for (int i = 7; i >= 0; i--) wbit(AW[i]);
        tick(H);
        chk("R6 ack held before timeout", 32'(sda_pull), 1);
        tick(TMO + 50);
        chk("R6 released after timeout", 32'(sda_pull), 0);
        b_stop();
        reg_read(8'h03, 8'hA5, "R6 recovery");

        // R7 START then STOP in the middle of a write
        b_start();
        wbyte(AW, ack);
        chk("R7 addr ack", 32'(ack), 1);
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_sda = 1'b1; tick(H);
        m_scl = 1'b0; tick(4);
        chk("R7 sda released", 32'(sda_pull), 0);
        wbyte(AW, ack);
        chk("R7 idle ignores bytes", 32'(ack), 0);
        b_stop();
        reg_read(8'h00, 8'h5A, "R7 recovery");

        // R8 / R9 alert and alert response
        reg_write(8'h42, 8'h02, "R8 mask");
        pulse_evt(0);
        chk("R8 masked event no alert", 32'(alert_n), 1);
        ara_read(1'b0, "R9 no alert");
        reg_write(8'h7C, 8'h04, "R8 enable");
        chk("R8 enabled but masked", 32'(alert_n), 1);
        pulse_evt(1);
        chk("R8 alert asserted", 32'(alert_n), 0);
        ara_read(1'b1, "R9 answered");
        chk("R9 alert dropped", 32'(alert_n), 1);
        ara_read(1'b0, "R9 second nack");
        reg_write(8'h41, 8'h02, "R8 clear");
        chk("R8 cleared no alert", 32'(alert_n), 1);
        pulse_evt(1);
        chk("R9 rearmed alert", 32'(alert_n), 0);
        reg_read(8'h41, 8'h03, "R8 sticky status");
        reg_write(8'h7C, 8'h00, "R8 disable");
        chk("R8 disabled alert", 32'(alert_n), 1);

        tick(10);
        chk("R10 pull only in SCL low", 32'(r10_viol), 0);
        chk("R2 scoreboard drained", 32'(exp_q.size()), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule